// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block sits beside a processor pipeline and decides what happens when a debug event strobe arrives. Using enable bits from the debug control register (an internal-debug enable and an external-debug enable), two bits from the machine state register (a debug enable and a wait enable) and a wait enable held by the debug port, it does one of three things. It raises a one-cycle debug-interrupt request. It freezes the core for an external debugger. Or it enters a wait-style freeze, in which the core stays stopped but can still leave to run an interrupt handler and come back.

While the core is frozen, the debug port can resume execution. It can also single-step, which releases the freeze for a set number of instruction-completion pulses and then freezes again. A 2-bit status code reports the current state. The bus-enable output is never dropped by a freeze.

Top module: `dbgm_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the controller in the running state. After reset the status code is 2'b00, and halt, irq_grant, dbg_irq and evt_pend are all 0. The status codes are 00 running, 01 frozen-external, 10 frozen-wait and 11 servicing-interrupt.
- R2: In the running state, if a debug event arrives with cr_int_en=1, ms_dbg_en=1 and not (cr_ext_en=1 and ms_dbg_en=1), dbg_irq is high for exactly the one cycle after the event edge. The state stays 00 and halt stays 0.
- R3: In the running state, if a debug event arrives with cr_ext_en=1 and ms_dbg_en=1, the state becomes 01 and halt becomes 1 after that edge, with no dbg_irq. This holds whatever the value of cr_int_en.
- R4: In the running state, if a debug event arrives with cr_int_en=0, cr_ext_en=0, ms_wait_en=1 and port_wait_en=1, the state becomes 10 and halt becomes 1. Any other enable combination not covered by R2 or R3 leaves the state at 00, halt at 0 and dbg_irq at 0.
- R5: In state 01, irq is ignored: the state stays 01, halt stays 1 and irq_grant stays 0.
- R6: In state 10, while no step is in progress and resume is low, irq moves the state to 11 with halt=0 and irq_grant=1. In state 11, irq_ret moves the state back to 10 with halt=1 and irq_grant=0.
- R7: A debug event in state 11 does not change the state and sets evt_pend to 1. evt_pend clears on the edge that takes irq_ret.
- R8: A debug event in state 01 or 10 has no effect on the state, on halt or on dbg_irq.
- R9: In state 01 or 10, port_resume returns the state to 00 with halt=0. port_resume takes priority over irq and port_step.
- R10: In state 01 or 10, port_step drops halt while the status code stays the same. Halt returns to 1 on the edge that takes the STEP_INSNS-th instr_done pulse. The default is STEP_INSNS=1.
- R11: bus_en is 1 in every state, including frozen and servicing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_evt | input | 1 | Debug event strobe |
| cr_int_en | input | 1 | Debug control: internal-debug enable |
| cr_ext_en | input | 1 | Debug control: external-debug enable |
| ms_dbg_en | input | 1 | Machine state: debug enable |
| ms_wait_en | input | 1 | Machine state: debug-wait enable |
| port_wait_en | input | 1 | Debug-port wait enable |
| irq | input | 1 | Interrupt request |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| port_resume | input | 1 | Debug-port resume command |
| port_step | input | 1 | Debug-port single-step command |
| instr_done | input | 1 | Instruction-completion pulse from pipeline |
| dbg_irq | output | 1 | Debug-interrupt request pulse |
| halt | output | 1 | Freeze request to the pipeline |
| irq_grant | output | 1 | Interrupt handler may run |
| bus_en | output | 1 | External bus enable, always 1 |
| evt_pend | output | 1 | Debug event held during handler |
| state_code | output | 2 | Current state code |

## Verification
The bench sweeps all 32 combinations of the five enable bits from the running state and computes the outcome from the priority rules. A design that ranked internal above external debug, or entered wait mode while a debug enable was set, fails that sweep. Directed sequences then probe the wait-mode round trip, an irq arriving in external freeze, and events that arrive while frozen or while a handler runs. A design that serviced interrupts in external freeze, lost the return to frozen-wait, or froze again on a late event would show the wrong status code. Step tests check that halt stays low until exactly the programmed number of completion pulses has arrived, and that resume wins over step and irq.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'b00,
    ST_FRZ_EXT  = 2'b01,
    ST_FRZ_WAIT = 2'b10,
    ST_SVC      = 2'b11
  } dbgm_state_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_IRQ,
    ACT_FRZ_EXT,
    ACT_FRZ_WAIT
  } dbgm_act_e;

  typedef struct packed {
    logic int_en;
    logic ext_en;
    logic msr_de;
    logic msr_we;
    logic port_we;
  } dbgm_en_t;

  function automatic logic is_frozen(dbgm_state_e s);
    return (s == ST_FRZ_EXT) || (s == ST_FRZ_WAIT);
  endfunction

endpackage

// File: rtl/dbgm_route.sv
module dbgm_route
  import dbgm_pkg::*;
(
  input  dbgm_en_t  en,
  output dbgm_act_e act
);
  logic ext_ok, int_ok, wait_ok;

  always_comb begin
    ext_ok  = en.ext_en & en.msr_de;
    int_ok  = en.int_en & en.msr_de;
    wait_ok = ~en.int_en & ~en.ext_en & en.msr_we & en.port_we;
    if (ext_ok)       act = ACT_FRZ_EXT;
    else if (int_ok)  act = ACT_IRQ;
    else if (wait_ok) act = ACT_FRZ_WAIT;
    else              act = ACT_NONE;
  end
endmodule

// File: rtl/dbgm_step.sv
module dbgm_step #(
  parameter int STEP_INSNS = 1,
  localparam int CW = (STEP_INSNS > 1) ? $clog2(STEP_INSNS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frozen,
  input  logic start,
  input  logic cancel,
  input  logic instr_done,
  output logic busy
);
  localparam logic [CW-1:0] LAST = CW'(STEP_INSNS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!frozen || cancel) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (instr_done) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/dbgm_fsm.sv
module dbgm_fsm
  import dbgm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        evt,
  input  dbgm_act_e   act,
  input  logic        irq,
  input  logic        irq_ret,
  input  logic        resume,
  input  logic        step_busy,
  output dbgm_state_e state,
  output logic        pend,
  output logic        irq_pulse,
  output logic        take_irq
);
  dbgm_state_e st_q, st_d;
  logic        pend_q, pend_d;
  logic        irqp_q, irqp_d;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    irqp_d   = 1'b0;
    take_irq = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (evt) begin
          unique case (act)
            ACT_FRZ_EXT:  st_d = ST_FRZ_EXT;
            ACT_FRZ_WAIT: st_d = ST_FRZ_WAIT;
            ACT_IRQ:      irqp_d = 1'b1;
            default:      st_d = ST_RUN;
          endcase
        end
      end
      ST_FRZ_EXT: begin
        if (resume) st_d = ST_RUN;
      end
      ST_FRZ_WAIT: begin
        if (resume) begin
          st_d = ST_RUN;
        end else if (irq && !step_busy) begin
          st_d     = ST_SVC;
          take_irq = 1'b1;
        end
      end
      ST_SVC: begin
        if (irq_ret) begin
          st_d   = ST_FRZ_WAIT;
          pend_d = 1'b0;
        end else if (evt) begin
          pend_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      pend_q <= 1'b0;
      irqp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      irqp_q <= irqp_d;
    end
  end

  assign state     = st_q;
  assign pend      = pend_q;
  assign irq_pulse = irqp_q;
endmodule

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
#(
  parameter int STEP_INSNS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dbg_evt,
  input  logic       cr_int_en,
  input  logic       cr_ext_en,
  input  logic       ms_dbg_en,
  input  logic       ms_wait_en,
  input  logic       port_wait_en,
  input  logic       irq,
  input  logic       irq_ret,
  input  logic       port_resume,
  input  logic       port_step,
  input  logic       instr_done,
  output logic       dbg_irq,
  output logic       halt,
  output logic       irq_grant,
  output logic       bus_en,
  output logic       evt_pend,
  output logic [1:0] state_code
);
  dbgm_en_t    en;
  dbgm_act_e   act;
  dbgm_state_e st;
  logic        pend, irq_pulse, take_irq, step_busy, frozen, step_go;

  assign en = '{int_en: cr_int_en, ext_en: cr_ext_en, msr_de: ms_dbg_en,
                msr_we: ms_wait_en, port_we: port_wait_en};

  dbgm_route u_route (.en(en), .act(act));

  dbgm_fsm u_fsm (
    .clk(clk), .rst(rst), .evt(dbg_evt), .act(act), .irq(irq),
    .irq_ret(irq_ret), .resume(port_resume), .step_busy(step_busy),
    .state(st), .pend(pend), .irq_pulse(irq_pulse), .take_irq(take_irq)
  );

  assign frozen  = is_frozen(st);
  assign step_go = port_step & ~port_resume & ~take_irq;

  dbgm_step #(.STEP_INSNS(STEP_INSNS)) u_step (
    .clk(clk), .rst(rst), .frozen(frozen), .start(step_go),
    .cancel(port_resume), .instr_done(instr_done), .busy(step_busy)
  );

  // outputs are decodes of flops only
  assign dbg_irq    = irq_pulse;
  assign halt       = frozen & ~step_busy;
  assign irq_grant  = (st == ST_SVC);
  assign bus_en     = 1'b1;
  assign evt_pend   = pend;
  assign state_code = st;
endmodule

// File: rtl/dbgm_ctrl_chk.sv
module dbgm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       dbg_evt,
  input logic       cr_ext_en,
  input logic       ms_dbg_en,
  input logic       irq,
  input logic       irq_ret,
  input logic       port_resume,
  input logic       dbg_irq,
  input logic       halt,
  input logic       irq_grant,
  input logic       bus_en,
  input logic [1:0] state_code
);
  // R11
  bus_on_chk: assert property (@(posedge clk) disable iff (rst) bus_en);

  // R3
  ext_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00 && dbg_evt && cr_ext_en && ms_dbg_en) |=> (state_code == 2'b01 && !dbg_irq));

  // R5
  ext_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b01 && irq && !port_resume) |=> (state_code == 2'b01 && !irq_grant));

  // R6
  wait_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b11 && irq_ret) |=> (state_code == 2'b10 && halt));

  // R2
  irq_running_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |-> (state_code == 2'b00 && !halt));

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 2'b01 || state_code == 2'b10) && port_resume) |=> (state_code == 2'b00 && !halt));

  // R10
  halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (state_code == 2'b01 || state_code == 2'b10));
endmodule

bind dbgm_ctrl dbgm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .dbg_evt(dbg_evt), .cr_ext_en(cr_ext_en),
  .ms_dbg_en(ms_dbg_en), .irq(irq), .irq_ret(irq_ret),
  .port_resume(port_resume), .dbg_irq(dbg_irq), .halt(halt),
  .irq_grant(irq_grant), .bus_en(bus_en), .state_code(state_code)
);

// File: tb/tb_dbgm_ctrl.sv
`timescale 1ns/1ps
module tb_dbgm_ctrl;
  localparam int STEPS = 2;

  logic clk = 0, rst = 1;
  logic dbg_evt = 0, cr_int_en = 0, cr_ext_en = 0, ms_dbg_en = 0, ms_wait_en = 0, port_wait_en = 0;
  logic irq = 0, irq_ret = 0, port_resume = 0, port_step = 0, instr_done = 0;
  logic dbg_irq, halt, irq_grant, bus_en, evt_pend;
  logic [1:0] state_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbgm_ctrl #(.STEP_INSNS(STEPS)) dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    dbg_evt = 0; irq = 0; irq_ret = 0; port_resume = 0; port_step = 0; instr_done = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic set_en(logic [4:0] v);
    {cr_int_en, cr_ext_en, ms_dbg_en, ms_wait_en, port_wait_en} = v;
  endtask

  initial begin
    #1;
    do_reset();
    // R1
    chk("R1 state", state_code, 2'b00);
    chk("R1 outs", {halt, irq_grant, dbg_irq, evt_pend}, 4'b0000);
    chk("R11 reset", bus_en, 1);

    // R2 R3 R4 sweep
    for (int v = 0; v < 32; v++) begin
      logic i, e, d, w, p;
      logic [1:0] es; logic ei;
      {i, e, d, w, p} = 5'(v);
      es = 2'b00; ei = 0;
      if (e && d) es = 2'b01;
      else if (i && d) ei = 1;
      else if (!i && !e && w && p) es = 2'b10;
      do_reset();
      set_en(5'(v));
      dbg_evt = 1; tick();
      chk("R2/R3/R4 state", state_code, es);
      chk("R2 dbg_irq", dbg_irq, ei);
      chk("R3/R4 halt", halt, es != 0);
      chk("R11 bus", bus_en, 1);
      tick();
      chk("R2 pulse one cycle", dbg_irq, 0);
    end

    // R5, R8, R10, R9 in external freeze
    do_reset(); set_en(5'b01100); dbg_evt = 1; tick();
    irq = 1; tick(); tick();
    chk("R5 state", state_code, 2'b01);
    chk("R5 grant", irq_grant, 0);
    chk("R5 halt", halt, 1);
    set_en(5'b10100); dbg_evt = 1; tick();
    chk("R8 ext state", state_code, 2'b01);
    chk("R8 ext dbg_irq", dbg_irq, 0);
    port_step = 1; tick();
    chk("R10 halt drop", halt, 0);
    chk("R10 code kept", state_code, 2'b01);
    instr_done = 1; tick();
    chk("R10 after 1 pulse", halt, 0);
    tick();
    chk("R10 no pulse", halt, 0);
    instr_done = 1; tick();
    chk("R10 rehalt", halt, 1);
    port_resume = 1; port_step = 1; irq = 1; tick();
    chk("R9 state", state_code, 2'b00);
    chk("R9 halt", halt, 0);

    // R6, R7, R8 wait mode round trip
    do_reset(); set_en(5'b00011); dbg_evt = 1; tick();
    chk("R4 wait", state_code, 2'b10);
    dbg_evt = 1; tick();
    chk("R8 wait state", state_code, 2'b10);
    chk("R8 wait halt", halt, 1);
    irq = 1; tick();
    chk("R6 svc", state_code, 2'b11);
    chk("R6 svc outs", {halt, irq_grant}, 2'b01);
    chk("R7 no pend", evt_pend, 0);
    dbg_evt = 1; tick();
    chk("R7 state kept", state_code, 2'b11);
    chk("R7 pend", evt_pend, 1);
    tick();
    chk("R7 pend held", evt_pend, 1);
    irq_ret = 1; tick();
    chk("R6 back", state_code, 2'b10);
    chk("R6 back outs", {halt, irq_grant}, 2'b10);
    chk("R7 pend clr", evt_pend, 0);
    chk("R11 wait", bus_en, 1);
    // irq blocked during step
    port_step = 1; tick();
    irq = 1; tick();
    chk("R6 step blocks irq", state_code, 2'b10);
    instr_done = 1; tick(); instr_done = 1; tick();
    chk("R10 wait rehalt", halt, 1);
    port_resume = 1; tick();
    chk("R9 wait resume", state_code, 2'b00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule